// File: doc/BRIEF.md
# Word-to-Byte Data Packer for an SPI Host

This block joins a 32-bit register port to the byte-wide transmit and receive queues of an SPI host controller, and it holds both queues itself. A store to the transmit data register breaks the word into bytes and enqueues them lowest lane first. A load from the receive data register dequeues up to four bytes and packs them into one word, with the first byte dequeued in the lowest lane. The serial engine takes transmit bytes from one end of the transmit queue and delivers received bytes into the receive queue.

Each register access completes in a single clock. When the queue fills partway through a store, the bytes that do not fit are lost and a one-cycle overflow strobe follows. When the queue runs dry partway through a load, the word is returned with its missing lanes zeroed and a one-cycle underflow strobe follows. The block also drives the empty and full flags and the transmit depth field of a 32-bit status word, and reports the receive depth on a separate port. A synchronous clear input empties both queues.

Top module: `spi_word_packer`

## Requirements
- R1: After a store of word W, the transmit byte port presents W[7:0] first, then W[15:8], W[23:16] and W[31:24] on successive pops.
- R2: A store accepts only as many bytes as the transmit queue has room for, taking them from the lowest lane up, and drops the rest. overflow_o is high for exactly the one cycle after any store that could not take all four bytes. status_o[29] (transmit full) is 1 whenever the transmit queue holds TX_DEPTH bytes.
- R3: One cycle after a load, rxdata_o holds the dequeued bytes, the oldest in bits [7:0], the next in [15:8], and so on.
- R4: A load that finds fewer than four bytes returns those bytes in the low lanes with the upper lanes zero, and underflow_o is high for the cycle after it. status_o[24] (receive empty) is 1 whenever the receive queue is empty.
- R5: rxdata_valid_o is high for exactly the one cycle after each load. rxdata_o keeps its value until the next load.
- R6: status_o[28] (transmit empty) is 1 exactly when the transmit queue is empty, so it reads 0 after any store made while the queue had room.
- R7: status_o[25] (receive full) is 1 exactly when the receive queue holds RX_DEPTH bytes, so it reads 0 after any load.
- R8: status_o[7:0] equals the transmit byte count divided by 4, rounded up. rx_qd_o gives the same measure for the receive queue.
- R9: In a cycle where bytes enter and leave the same queue, its count changes by the number of bytes entered minus the number removed.
- R10: fifo_clr_i empties both queues at the next clock edge and takes priority over any push or pop in that cycle.
- R11: After reset, status_o reads 0x1100_0000 (both empty flags set, all else zero) and all strobes and rxdata_o are low.
- R12: A transmit pop while the transmit queue is empty is ignored. A receive push while the receive queue is full is discarded and leaves the contents unchanged.
- R13: status_o bits other than [7:0], 24, 25, 28 and 29 are always 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_clr_i | input | 1 | Synchronous clear of both queues |
| txdata_we_i | input | 1 | Store strobe for the transmit data register |
| txdata_i | input | WORD_W | Word to split and enqueue |
| rxdata_re_i | input | 1 | Load strobe for the receive data register |
| rxdata_o | output | WORD_W | Packed word from the last load |
| rxdata_valid_o | output | 1 | rxdata_o was updated by the load of the previous cycle |
| overflow_o | output | 1 | One-cycle strobe: the previous store dropped bytes |
| underflow_o | output | 1 | One-cycle strobe: the previous load came up short |
| tx_byte_o | output | 8 | Oldest byte in the transmit queue |
| tx_byte_valid_o | output | 1 | Transmit queue is not empty |
| tx_byte_pop_i | input | 1 | Serial engine takes tx_byte_o |
| rx_byte_i | input | 8 | Received byte from the serial engine |
| rx_byte_push_i | input | 1 | Enqueue rx_byte_i |
| status_o | output | 32 | Depth and flag fields of the status word |
| rx_qd_o | output | 8 | Receive depth in words, rounded up |

## Verification
A wrong count or pointer shows up at the ports within one cycle. The depth field or an empty or full flag goes wrong at once, and a pointer slip puts the wrong byte on tx_byte_o or the wrong lane in the next loaded word. A bad free-space or available-byte figure first shows as an overflow or underflow strobe in the wrong cycle, and then as words that are missing bytes or carry extra bytes several loads later. For that reason the reference model compares every output on every cycle, including the lane contents of every loaded word, so a fault is reported in the cycle where it first reaches a port.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int BYTE_W      = 8;
  localparam int ST_QD_LSB   = 0;
  localparam int ST_QD_W     = 8;
  localparam int ST_RX_EMPTY = 24;
  localparam int ST_RX_FULL  = 25;
  localparam int ST_TX_EMPTY = 28;
  localparam int ST_TX_FULL  = 29;

  // bytes -> whole words, saturated to the 8-bit depth field
  function automatic logic [7:0] words_ceil(input int bytes, input int lanes);
    int w;
    w = (bytes + lanes - 1) / lanes;
    if (w > 255) w = 255;
    return 8'(w);
  endfunction
endpackage

// File: rtl/spk_byte_fifo.sv
module spk_byte_fifo #(
  parameter int DEPTH     = 16,
  parameter int IN_LANES  = 1,
  parameter int OUT_LANES = 1,
  parameter int BYTE_W    = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1,
  localparam int INW      = $clog2(IN_LANES + 1),
  localparam int OUTW     = $clog2(OUT_LANES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic [INW-1:0]                push_n_i,
  input  logic [IN_LANES*BYTE_W-1:0]    push_data_i,
  input  logic [OUTW-1:0]               pop_n_i,
  output logic [OUT_LANES*BYTE_W-1:0]   peek_o,
  output logic [CW-1:0]                 count_o
);
  // DEPTH must be a power of two: pointers wrap by overflow
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(push_n_i);
      rd_ptr_q <= rd_ptr_q + AW'(pop_n_i);
      count_q  <= count_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < IN_LANES; k++) begin
      if (!clr_i && k < int'(push_n_i))
        mem_q[wr_ptr_q + AW'(k)] <= push_data_i[k*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    for (int k = 0; k < OUT_LANES; k++)
      peek_o[k*BYTE_W +: BYTE_W] = mem_q[rd_ptr_q + AW'(k)];
  end

  assign count_o = count_q;

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= DEPTH);
  p_push_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (int'(push_n_i) <= DEPTH - int'(count_q)));
  p_pop_avail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (int'(pop_n_i) <= int'(count_q)));
endmodule

// File: rtl/spk_tx_split.sv
module spk_tx_split #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int CW    = 5,
  parameter int LW    = 3
) (
  input  logic          we_i,
  input  logic [CW-1:0] count_i,
  output logic [LW-1:0] push_n_o,
  output logic          ovf_o
);
  int free_b;
  always_comb begin
    free_b = DEPTH - int'(count_i);
    if (!we_i)                push_n_o = '0;
    else if (free_b >= LANES) push_n_o = LW'(LANES);
    else                      push_n_o = LW'(free_b);
    ovf_o = we_i && (free_b < LANES);
  end
endmodule

// File: rtl/spk_rx_gather.sv
module spk_rx_gather #(
  parameter int LANES  = 4,
  parameter int CW     = 5,
  parameter int LW     = 3,
  parameter int BYTE_W = 8
) (
  input  logic                     re_i,
  input  logic [CW-1:0]            count_i,
  input  logic [LANES*BYTE_W-1:0]  peek_i,
  output logic [LW-1:0]            pop_n_o,
  output logic [LANES*BYTE_W-1:0]  word_o,
  output logic                     short_o
);
  int avail, n;
  always_comb begin
    avail = int'(count_i);
    n     = !re_i ? 0 : (avail < LANES ? avail : LANES);
    pop_n_o = LW'(n);
    word_o  = '0;
    for (int k = 0; k < LANES; k++)
      if (k < n) word_o[k*BYTE_W +: BYTE_W] = peek_i[k*BYTE_W +: BYTE_W];
    short_o = re_i && (avail < LANES);
  end
endmodule

// File: rtl/spk_status.sv
module spk_status
  import spk_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int LANES    = 4,
  parameter int TCW      = 5,
  parameter int RCW      = 5
) (
  input  logic [TCW-1:0] tx_count_i,
  input  logic [RCW-1:0] rx_count_i,
  output logic [31:0]    status_o,
  output logic [7:0]     rx_qd_o
);
  always_comb begin
    status_o = '0;
    status_o[ST_QD_LSB +: ST_QD_W] = words_ceil(int'(tx_count_i), LANES);
    status_o[ST_RX_EMPTY] = (rx_count_i == '0);
    status_o[ST_RX_FULL]  = (rx_count_i == RCW'(RX_DEPTH));
    status_o[ST_TX_EMPTY] = (tx_count_i == '0);
    status_o[ST_TX_FULL]  = (tx_count_i == TCW'(TX_DEPTH));
    rx_qd_o = words_ceil(int'(rx_count_i), LANES);
  end
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
  import spk_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int WORD_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_clr_i,
  input  logic              txdata_we_i,
  input  logic [WORD_W-1:0] txdata_i,
  input  logic              rxdata_re_i,
  output logic [WORD_W-1:0] rxdata_o,
  output logic              rxdata_valid_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [7:0]        tx_byte_o,
  output logic              tx_byte_valid_o,
  input  logic              tx_byte_pop_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_byte_push_i,
  output logic [31:0]       status_o,
  output logic [7:0]        rx_qd_o
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int LW    = $clog2(LANES + 1);
  localparam int TCW   = $clog2(TX_DEPTH) + 1;
  localparam int RCW   = $clog2(RX_DEPTH) + 1;

  logic [TCW-1:0]    tx_cnt;
  logic [RCW-1:0]    rx_cnt;
  logic [LW-1:0]     tx_push_n, rx_pop_n;
  logic              ovf_c, short_c;
  logic              tx_pop_ok, rx_push_ok;
  logic [WORD_W-1:0] rx_peek, word_c;

  assign tx_pop_ok  = tx_byte_pop_i && (tx_cnt != '0);
  assign rx_push_ok = rx_byte_push_i && (rx_cnt != RCW'(RX_DEPTH));

  spk_tx_split #(.DEPTH(TX_DEPTH), .LANES(LANES), .CW(TCW), .LW(LW)) u_split (
    .we_i(txdata_we_i), .count_i(tx_cnt), .push_n_o(tx_push_n), .ovf_o(ovf_c)
  );

  spk_byte_fifo #(.DEPTH(TX_DEPTH), .IN_LANES(LANES), .OUT_LANES(1), .BYTE_W(BYTE_W)) u_tx_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fifo_clr_i),
    .push_n_i(tx_push_n), .push_data_i(txdata_i),
    .pop_n_i(tx_pop_ok), .peek_o(tx_byte_o), .count_o(tx_cnt)
  );

  spk_byte_fifo #(.DEPTH(RX_DEPTH), .IN_LANES(1), .OUT_LANES(LANES), .BYTE_W(BYTE_W)) u_rx_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(fifo_clr_i),
    .push_n_i(rx_push_ok), .push_data_i(rx_byte_i),
    .pop_n_i(rx_pop_n), .peek_o(rx_peek), .count_o(rx_cnt)
  );

  spk_rx_gather #(.LANES(LANES), .CW(RCW), .LW(LW), .BYTE_W(BYTE_W)) u_gather (
    .re_i(rxdata_re_i), .count_i(rx_cnt), .peek_i(rx_peek),
    .pop_n_o(rx_pop_n), .word_o(word_c), .short_o(short_c)
  );

  spk_status #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .LANES(LANES), .TCW(TCW), .RCW(RCW)) u_stat (
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt), .status_o(status_o), .rx_qd_o(rx_qd_o)
  );

  assign tx_byte_valid_o = (tx_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxdata_o       <= '0;
      rxdata_valid_o <= 1'b0;
      overflow_o     <= 1'b0;
      underflow_o    <= 1'b0;
    end else begin
      rxdata_valid_o <= rxdata_re_i;
      overflow_o     <= ovf_c;
      underflow_o    <= short_c;
      if (rxdata_re_i) rxdata_o <= word_c;
    end
  end

  p_load_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxdata_re_i |=> rxdata_valid_o);
  p_underflow_with_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> rxdata_valid_o);
  p_store_not_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txdata_we_i && !fifo_clr_i |=> !status_o[ST_TX_EMPTY]);
  p_load_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxdata_re_i |=> !status_o[ST_RX_FULL]);
  p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> status_o[ST_TX_EMPTY] && status_o[ST_RX_EMPTY]);
  p_pop_empty_keeps_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_byte_valid_o && !txdata_we_i |=> !tx_byte_valid_o);
endmodule

// File: tb/sim_spi_word_packer.sv
module sim_spi_word_packer;
  localparam int TXD = 16;
  localparam int RXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, we = 1'b0, re = 1'b0, pop = 1'b0, push = 1'b0;
  logic [31:0] wd = '0;
  logic [7:0]  pb = '0;
  logic [31:0] rdata, status;
  logic        rvalid, ovf, und, tvalid;
  logic [7:0]  tbyte, rxqd;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_word_packer #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .WORD_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_clr_i(clr),
    .txdata_we_i(we), .txdata_i(wd), .rxdata_re_i(re),
    .rxdata_o(rdata), .rxdata_valid_o(rvalid), .overflow_o(ovf), .underflow_o(und),
    .tx_byte_o(tbyte), .tx_byte_valid_o(tvalid), .tx_byte_pop_i(pop),
    .rx_byte_i(pb), .rx_byte_push_i(push), .status_o(status), .rx_qd_o(rxqd)
  );

  // reference model
  byte unsigned txq[$];
  byte unsigned rxq[$];
  logic [31:0] e_rdata = '0;
  logic e_rv = 0, e_ovf = 0, e_und = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      e_rdata = '0; e_rv = 0; e_ovf = 0; e_und = 0;
    end else begin
      int tsz, nfit, rsz, np;
      tsz  = txq.size();
      nfit = (TXD - tsz < 4) ? TXD - tsz : 4;
      e_ovf = we && nfit < 4;
      if (pop && tsz > 0) void'(txq.pop_front());
      if (we) for (int i = 0; i < nfit; i++) txq.push_back(wd[8*i +: 8]);
      rsz = rxq.size();
      np  = rsz < 4 ? rsz : 4;
      e_rv  = re;
      e_und = re && np < 4;
      if (re) begin
        e_rdata = '0;
        for (int i = 0; i < np; i++) e_rdata[8*i +: 8] = rxq.pop_front();
      end
      if (push && rsz < RXD) rxq.push_back(pb);
      if (clr) begin txq.delete(); rxq.delete(); end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    int t = txq.size(), r = rxq.size();
    s[7:0] = 8'((t + 3) / 4);
    s[24] = (r == 0); s[25] = (r == RXD);
    s[28] = (t == 0); s[29] = (t == TXD);
    return s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] es;
      es = exp_status();
      chk("R8 txqd",          {24'd0, status[7:0]}, {24'd0, es[7:0]});
      chk("R4 rx_empty",      {31'd0, status[24]}, {31'd0, es[24]});
      chk("R7 rx_full",       {31'd0, status[25]}, {31'd0, es[25]});
      chk("R6 tx_empty",      {31'd0, status[28]}, {31'd0, es[28]});
      chk("R2 tx_full",       {31'd0, status[29]}, {31'd0, es[29]});
      chk("R13 unused bits",  status & 32'hCCFF_FF00, 32'd0);
      chk("R8 rx_qd",         {24'd0, rxqd}, 32'((rxq.size() + 3) / 4));
      chk("R12 tx_valid",     {31'd0, tvalid}, {31'd0, txq.size() != 0});
      if (txq.size() != 0) chk("R1 tx_byte", {24'd0, tbyte}, {24'd0, txq[0]});
      chk("R2 overflow",      {31'd0, ovf}, {31'd0, e_ovf});
      chk("R4 underflow",     {31'd0, und}, {31'd0, e_und});
      chk("R5 rvalid",        {31'd0, rvalid}, {31'd0, e_rv});
      chk("R3 rdata",         rdata, e_rdata);
    end
  end

  task automatic step(input logic w, input logic [31:0] d, input logic r,
                      input logic p, input logic ps, input logic [7:0] b, input logic c);
    we = w; wd = d; re = r; pop = p; push = ps; pb = b; clr = c;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) step(0, '0, 0, 0, 0, '0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset status", status, 32'h1100_0000);
    chk("R11 reset strobes", {29'd0, rvalid, ovf, und}, 32'd0);
    chk("R11 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R6: lane order on the transmit side
    step(1, 32'h4433_2211, 0, 0, 0, '0, 0);
    chk("R6 tx_empty after store", {31'd0, status[28]}, 32'd0);
    chk("R1 first byte", {24'd0, tbyte}, 32'h11);
    step(0, '0, 0, 1, 0, '0, 0); chk("R1 second byte", {24'd0, tbyte}, 32'h22);
    step(0, '0, 0, 1, 0, '0, 0); chk("R1 third byte",  {24'd0, tbyte}, 32'h33);
    step(0, '0, 0, 1, 0, '0, 0); chk("R1 fourth byte", {24'd0, tbyte}, 32'h44);
    step(0, '0, 0, 1, 0, '0, 0); chk("R12 drained",    {31'd0, tvalid}, 32'd0);

    // R2: fifth store into a 16-byte queue overflows
    for (int i = 0; i < 4; i++) step(1, 32'h0302_0100 + 32'h0404_0404 * i, 0, 0, 0, '0, 0);
    chk("R2 full flag", {31'd0, status[29]}, 32'd1);
    chk("R2 no overflow yet", {31'd0, ovf}, 32'd0);
    chk("R8 txqd full", {24'd0, status[7:0]}, 32'd4);
    step(1, 32'hDEAD_BEEF, 0, 0, 0, '0, 0);
    chk("R2 overflow strobe", {31'd0, ovf}, 32'd1);
    idle(1);
    chk("R2 strobe one cycle", {31'd0, ovf}, 32'd0);
    for (int i = 0; i < 17; i++) step(0, '0, 0, 1, 0, '0, 0);
    step(1, 32'hCAFE_F00D, 0, 0, 0, '0, 0);
    chk("R12 pop on empty ignored", {24'd0, tbyte}, 32'h0D);
    for (int i = 0; i < 4; i++) step(0, '0, 0, 1, 0, '0, 0);

    // R3 / R4 / R5: receive packing
    for (int i = 0; i < 6; i++) step(0, '0, 0, 0, 1, 8'hA0 + 8'(i), 0);
    chk("R8 rx_qd six bytes", {24'd0, rxqd}, 32'd2);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R3 packed word", rdata, 32'hA3A2_A1A0);
    chk("R5 valid", {31'd0, rvalid}, 32'd1);
    chk("R4 no underflow", {31'd0, und}, 32'd0);
    idle(1);
    chk("R5 valid one cycle", {31'd0, rvalid}, 32'd0);
    chk("R5 data held", rdata, 32'hA3A2_A1A0);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R4 partial word", rdata, 32'h0000_A5A4);
    chk("R4 underflow strobe", {31'd0, und}, 32'd1);
    chk("R4 rx empty", {31'd0, status[24]}, 32'd1);

    // R7 / R12: fill receive queue, one extra push dropped
    for (int i = 0; i < 17; i++) step(0, '0, 0, 0, 1, 8'h10 + 8'(i), 0);
    chk("R7 rx full", {31'd0, status[25]}, 32'd1);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R3 first full word", rdata, 32'h1312_1110);
    chk("R7 full cleared by load", {31'd0, status[25]}, 32'd0);
    step(0, '0, 1, 0, 0, '0, 0);
    step(0, '0, 1, 0, 0, '0, 0);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R12 last word unchanged", rdata, 32'h1F1E_1D1C);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R12 extra byte dropped", rdata, 32'd0);
    chk("R12 underflow on empty", {31'd0, und}, 32'd1);

    // R9: push and load in the same cycle
    for (int i = 0; i < 8; i++) step(0, '0, 0, 0, 1, 8'h50 + 8'(i), 0);
    step(0, '0, 1, 0, 1, 8'h58, 0);
    chk("R9 word during push", rdata, 32'h5352_5150);
    chk("R9 rx_qd after 8+1-4", {24'd0, rxqd}, 32'd2);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R9 next word", rdata, 32'h5756_5554);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R9 pushed byte kept", rdata, 32'h0000_0058);

    // R10: clear wins over same-cycle traffic
    step(1, 32'h1234_5678, 0, 0, 0, '0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 1, 8'h77, 0);
    step(1, 32'hFFFF_FFFF, 0, 0, 1, 8'h66, 1);
    chk("R10 both empty", status, 32'h1100_0000);
    chk("R10 tx not valid", {31'd0, tvalid}, 32'd0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rr;
      rr = $urandom;
      step(rr[1:0] == 2'b00, $urandom, rr[3:2] == 2'b00, rr[4], rr[5], 8'(rr[15:8]),
           rr[21:16] == 6'd0);
    end
    idle(2);
    finish_run();
  end
endmodule